// File: doc/BRIEF.md
# Five-Pin GPIO Controller with Register-Bit Monitor

This block controls five general purpose pins through a byte-wide register bus. Each pin has its own direction bit. An output pin drives a value that software writes. An input pin is passed through a two-flop synchronizer, and its state can be read back. One global monitor switch moves all five pins into a third mode together. In that mode each pin mirrors a single bit taken from a wider indirect register space that sits outside the block. Each pin has a table entry that names the byte address and the bit index within that byte.

The indirect space is reached through a plain lookup port. The block puts an address on `look_addr` and expects the selected byte back on `look_data` combinationally in the same cycle. The controller scans the five table entries in turn, one entry per clock. Each pin's monitored value is therefore refreshed once every five cycles. The register bus is control traffic only and has no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational and is valid while `reg_rd` is high.

Register map, with the default base 0x20:
- 0x20 is the control register. Bits [4:0] are the pin directions (1 = output) and bit 7 is the monitor switch.
- 0x21 to 0x25 hold the monitor byte address for pins 0 to 4.
- 0x28 is the level register. A write sets the drive values in bits [4:0]. A read returns the per-pin level.
- 0x29 to 0x2D hold the bit index, in bits [2:0], for pins 0 to 4.

Top module: `gpio_bitwatch`

## Requirements
- R1: After reset, every pin is an input (`pin_oe`=0), the monitor switch is off, and every register from 0x20 to 0x2D reads 0 while the pins are held low.
- R2: `pin_oe[i]` equals control bit i. With the monitor off, `pin_out` equals the drive value last written to bits [4:0] of 0x28.
- R3: With the monitor off, the level of an input pin reads the pin's state with two clock edges of latency: the new value is not visible after one edge and is visible after two.
- R4: With the monitor off, the level of an output pin reads its drive value.
- R5: With the monitor on, level bit i reads bit `tbit[i]` of the indirect byte at `taddr[i]`. The reading reflects changes in the indirect space within 6 cycles, whatever the pin's direction.
- R6: With the monitor on, an output pin drives its monitored bit on `pin_out`. Turning the monitor off returns every pin to its normal drive or sense behaviour together.
- R7: The table address for pin i is at 0x21+i, and its full 8 bits read back. The bit index for pin i is at 0x29+i; only bits [2:0] are stored and the other bits read 0.
- R8: Reads of unmapped addresses, and of unused bits (control bits 6:5, level bits 7:5), return 0. Writes to unmapped addresses change no register.
- R9: `look_addr` steps through the table entries in pin order 0,1,2,3,4,0,... and advances one entry per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, combinational, 0 when `reg_rd` is low |
| look_addr | output | 8 | Indirect-space address being polled |
| look_data | input | 8 | Byte returned for `look_addr` in the same cycle |
| pin_in | input | 5 | Raw pin inputs, asynchronous |
| pin_out | output | 5 | Pin output values |
| pin_oe | output | 5 | Pin output enables |

## Verification
The assertions assume that `look_data` is a combinational function of `look_addr` that settles within the cycle. They also assume that `pin_in` changes no more than once per clock, so that a value sampled two edges earlier is well defined. The bench models the indirect space as a byte array indexed directly by `look_addr`. It changes `pin_in` and the array contents only at falling edges, and it drives at most one bus strobe at a time. The bench sweeps all 32 direction patterns, all 32 input patterns, and all 8 bit indices on every pin.

// File: rtl/gpio_bitwatch_pkg.sv
package gpio_bitwatch_pkg;
  // offsets from the base address
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_TADDR  = 1;
  localparam int unsigned OFS_LEVEL  = 8;
  localparam int unsigned OFS_TBIT   = 9;
  // bit position of the global monitor switch in the control byte
  localparam int unsigned MON_EN_BIT = 7;
endpackage

// File: rtl/gpio_bitwatch_sync.sv
module gpio_bitwatch_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [1:0]   warm;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        dout[i]   <= 1'b0;
      end else begin
        stage1[i] <= din[i];
        dout[i]   <= stage1[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm <= 2'd0;
    else if (warm != 2'd2)  warm <= warm + 2'd1;
  end

  // R3
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_bitwatch_table.sv
module gpio_bitwatch_table #(
  parameter int unsigned N  = 5,
  parameter int unsigned AW = 8,
  parameter int unsigned BW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    we_addr,
  input  logic [N-1:0]    we_bit,
  input  logic [AW-1:0]   wdata_addr,
  input  logic [BW-1:0]   wdata_bit,
  output logic [N*AW-1:0] tab_addr,
  output logic [N*BW-1:0] tab_bit
);
  for (genvar i = 0; i < N; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tab_addr[i*AW +: AW] <= '0;
        tab_bit[i*BW +: BW]  <= '0;
      end else begin
        if (we_addr[i]) tab_addr[i*AW +: AW] <= wdata_addr;
        if (we_bit[i])  tab_bit[i*BW +: BW]  <= wdata_bit;
      end
    end
  end

  // R7
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_addr == '0 && we_bit == '0) |=> ($stable(tab_addr) && $stable(tab_bit)));
endmodule

// File: rtl/gpio_bitwatch_poll.sv
module gpio_bitwatch_poll #(
  parameter int unsigned N  = 5,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned BW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N*AW-1:0] tab_addr,
  input  logic [N*BW-1:0] tab_bit,
  output logic [AW-1:0]   look_addr,
  input  logic [DW-1:0]   look_data,
  output logic [N-1:0]    mon_bits
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] idx;
  logic [BW-1:0] sel_bit;

  assign look_addr = tab_addr[int'(idx)*AW +: AW];
  assign sel_bit   = tab_bit[int'(idx)*BW +: BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      mon_bits <= '0;
    end else begin
      idx           <= (idx == IW'(N-1)) ? '0 : idx + 1'b1;
      mon_bits[idx] <= look_data[sel_bit];
    end
  end

  // R9
  poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < N);

  // R5: only the entry polled in the previous cycle may change
  mon_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mon_bits ^ $past(mon_bits)) & ~(N'(1) << $past(idx))) == '0));
endmodule

// File: rtl/gpio_bitwatch.sv
module gpio_bitwatch
  import gpio_bitwatch_pkg::*;
#(
  parameter int unsigned   NPINS = 5,
  parameter int unsigned   AW    = 8,
  parameter int unsigned   DW    = 8,
  parameter logic [AW-1:0] BASE  = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_wr,
  input  logic             reg_rd,
  output logic [DW-1:0]    reg_rdata,
  output logic [AW-1:0]    look_addr,
  input  logic [DW-1:0]    look_data,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int unsigned   BW      = $clog2(DW);
  localparam logic [AW-1:0] A_CTRL  = BASE + AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_LEVEL = BASE + AW'(OFS_LEVEL);

  logic [NPINS-1:0]    dir_q, drive_q, sensed, mon_bits, level;
  logic                mon_en_q;
  logic [NPINS-1:0]    hit_ta, hit_tb;
  logic                hit_ctrl, hit_level, hit_any;
  logic [NPINS*AW-1:0] tab_addr;
  logic [NPINS*BW-1:0] tab_bit;

  assign hit_ctrl  = (reg_addr == A_CTRL);
  assign hit_level = (reg_addr == A_LEVEL);
  for (genvar i = 0; i < NPINS; i++) begin : g_dec
    assign hit_ta[i] = (reg_addr == BASE + AW'(OFS_TADDR + i));
    assign hit_tb[i] = (reg_addr == BASE + AW'(OFS_TBIT + i));
  end
  assign hit_any = hit_ctrl | hit_level | (|hit_ta) | (|hit_tb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      drive_q  <= '0;
      mon_en_q <= 1'b0;
    end else if (reg_wr) begin
      if (hit_ctrl) begin
        dir_q    <= reg_wdata[NPINS-1:0];
        mon_en_q <= reg_wdata[MON_EN_BIT];
      end
      if (hit_level) drive_q <= reg_wdata[NPINS-1:0];
    end
  end

  gpio_bitwatch_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(sensed)
  );

  gpio_bitwatch_table #(.N(NPINS), .AW(AW), .BW(BW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .we_addr(hit_ta & {NPINS{reg_wr}}),
    .we_bit(hit_tb & {NPINS{reg_wr}}),
    .wdata_addr(reg_wdata[AW-1:0]),
    .wdata_bit(reg_wdata[BW-1:0]),
    .tab_addr(tab_addr), .tab_bit(tab_bit)
  );

  gpio_bitwatch_poll #(.N(NPINS), .AW(AW), .DW(DW), .BW(BW)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .tab_addr(tab_addr), .tab_bit(tab_bit),
    .look_addr(look_addr), .look_data(look_data),
    .mon_bits(mon_bits)
  );

  assign level   = mon_en_q ? mon_bits : ((dir_q & drive_q) | (~dir_q & sensed));
  assign pin_out = mon_en_q ? mon_bits : drive_q;
  assign pin_oe  = dir_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (hit_ctrl) begin
        reg_rdata[NPINS-1:0]  = dir_q;
        reg_rdata[MON_EN_BIT] = mon_en_q;
      end
      if (hit_level) reg_rdata[NPINS-1:0] = level;
      for (int i = 0; i < NPINS; i++) begin
        if (hit_ta[i]) reg_rdata = DW'(tab_addr[i*AW +: AW]);
        if (hit_tb[i]) reg_rdata = DW'(tab_bit[i*BW +: BW]);
      end
    end
  end

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && hit_ctrl) |=> $stable(pin_oe));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !mon_en_q) |=> $stable(pin_out));

  // R8
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !hit_any) |-> (reg_rdata == '0));

  // R8
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !hit_any) |=> ($stable(dir_q) && $stable(drive_q) && $stable(mon_en_q)));
endmodule

// File: tb/gpio_bitwatch_bench.sv
`timescale 1ns/1ps
module gpio_bitwatch_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] look_addr, look_data;
  logic [4:0] pin_in = '0, pin_out, pin_oe;
  logic [7:0] space [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign look_data = space[look_addr];

  gpio_bitwatch u_gpio_bitwatch (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .look_addr(look_addr), .look_data(look_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v, snap [14];
    logic [4:0] expl, drv;
    logic [7:0] ta [5];
    logic [7:0] seen [6];
    int first;
    for (int a = 0; a < 256; a++) space[a] = 8'(a * 29 + 7);
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(2);

    // R1 reset state
    check(pin_oe == 5'h0, "R1 oe", pin_oe, 0);
    for (int a = 8'h20; a <= 8'h2D; a++) begin
      rd(8'(a), v);
      check(v == 8'h00, "R1 reg", v, 0);
    end

    // R7 table readback
    for (int i = 0; i < 5; i++) begin
      wr(8'(8'h21 + i), 8'(8'h90 + i * 13));
      wr(8'(8'h29 + i), 8'hF8 | 8'(i + 2));
    end
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      rd(8'(8'h21 + i), v);
      check(v == 8'(8'h90 + i * 13), "R7 taddr", v, 8'h90 + i * 13);
      rd(8'(8'h29 + i), v);
      check(v == 8'(i + 2), "R7 tbit", v, i + 2);
    end

    // R2 R4 direction sweep with monitor off
    pin_in = 5'h0A;
    wait_cycles(3);
    for (int d = 0; d < 32; d++) begin
      drv = 5'(d) ^ 5'h15;
      wr(8'h28, {3'b111, drv});
      wr(8'h20, 8'(d));
      check(pin_oe == 5'(d), "R2 oe", pin_oe, d);
      check(pin_out == drv, "R2 out", pin_out, drv);
      expl = (5'(d) & drv) | (~5'(d) & pin_in);
      rd(8'h28, v);
      check(v == {3'b000, expl}, "R4 level", v, expl);
    end

    // R3 synchronizer latency sweep
    wr(8'h20, 8'h00);
    wait_cycles(3);
    for (int p = 0; p < 32; p++) begin
      logic [4:0] prev;
      prev = pin_in;
      pin_in = 5'(p ^ 9);
      @(negedge clk);
      rd(8'h28, v);
      check(v[4:0] == prev, "R3 one edge", v, prev);
      @(negedge clk);
      rd(8'h28, v);
      check(v[4:0] == 5'(p ^ 9), "R3 two edges", v, p ^ 9);
    end

    // R9 poll order
    for (int i = 0; i < 5; i++) begin
      ta[i] = 8'(8'h11 + 8'h10 * i);
      wr(8'(8'h21 + i), ta[i]);
    end
    for (int k = 0; k < 6; k++) begin
      seen[k] = look_addr;
      @(negedge clk);
    end
    first = -1;
    for (int i = 0; i < 5; i++) if (ta[i] == seen[0]) first = i;
    check(first >= 0, "R9 start", seen[0], ta[0]);
    if (first < 0) first = 0;
    for (int k = 1; k < 6; k++)
      check(seen[k] == ta[(first + k) % 5], "R9 step", seen[k], ta[(first + k) % 5]);

    // R5 R6 monitor sweep over all bit indices, outputs
    wr(8'h20, 8'h9F);
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 5; p++) begin
        ta[p] = 8'(p * 41 + b * 7 + 3);
        wr(8'(8'h21 + p), ta[p]);
        wr(8'(8'h29 + p), 8'(b));
      end
      wait_cycles(6);
      for (int p = 0; p < 5; p++) expl[p] = space[ta[p]][b];
      rd(8'h28, v);
      check(v == {3'b000, expl}, "R5 level", v, expl);
      check(pin_out == expl, "R6 out", pin_out, expl);
    end
    // R5 tracks changes in the indirect space
    space[ta[0]] = ~space[ta[0]];
    space[ta[3]] = ~space[ta[3]];
    wait_cycles(6);
    for (int p = 0; p < 5; p++) expl[p] = space[ta[p]][7];
    rd(8'h28, v);
    check(v == {3'b000, expl}, "R5 follow", v, expl);
    // R5 input pins in monitor mode still report the monitored bit
    wr(8'h20, 8'h80);
    pin_in = ~expl;
    wait_cycles(4);
    rd(8'h28, v);
    check(v == {3'b000, expl}, "R5 input mon", v, expl);
    check(pin_oe == 5'h0, "R5 oe", pin_oe, 0);
    // R6 leaving monitor mode restores all pins together
    wr(8'h28, 8'h06);
    wr(8'h20, 8'h03);
    wait_cycles(1);
    check(pin_out == 5'h06, "R6 exit out", pin_out, 6);
    rd(8'h28, v);
    expl = (5'h03 & 5'h06) | (~5'h03 & pin_in);
    check(v == {3'b000, expl}, "R6 exit level", v, expl);

    // R8 reserved bits and addresses
    wr(8'h20, 8'hFF);
    rd(8'h20, v);
    check(v == 8'h9F, "R8 ctrl bits", v, 8'h9F);
    wr(8'h20, 8'h05);
    rd(8'h28, v);
    check(v[7:5] == 3'b000, "R8 level bits", v, 0);
    for (int a = 0; a < 14; a++) rd(8'(8'h20 + a), snap[a]);
    wr(8'h27, 8'hFF); wr(8'h2E, 8'hFF); wr(8'h1F, 8'hFF); wr(8'h00, 8'hFF);
    wait_cycles(6);
    for (int a = 0; a < 14; a++) begin
      if (a == 8) continue;
      rd(8'(8'h20 + a), v);
      check(v == snap[a], "R8 write ignored", v, snap[a]);
    end
    check(pin_oe == 5'h05, "R8 oe kept", pin_oe, 5);
    foreach (ta[i]) begin
      rd(8'(i == 0 ? 8'h27 : i == 1 ? 8'h2E : i == 2 ? 8'h1F : i == 3 ? 8'h00 : 8'hFF), v);
      check(v == 8'h00, "R8 reserved read", v, 0);
    end

    done = 1;
    finish_run();
  end
endmodule